// File: doc/BRIEF.md
# Serial Control Register Loader

This block takes control words from a three-wire serial port (shift clock, data, latch strobe) and holds them in two parallel registers that steer a downstream audio path. Bits are taken on each rising edge of the shift clock, least significant bit first. After sixteen bits the word stands complete. A falling edge on the latch strobe then commits it. The top bit of the word routes it either to the configuration register or to the attenuation register. The attenuation register carries the output level, the de-emphasis enable and select, and the mute bit.

The three serial inputs are asynchronous to the system clock. Each passes through a two-stage synchroniser, and edges are found on the synchronised copies. A latch edge that arrives before a full word has been shifted in throws that word away. An active-low initialise input, already in the system clock domain, clears both registers and any partial word.

Top module: `ctl_word_loader`

## Requirements
- R1: After reset, every output is zero.
- R2: The first bit shifted in becomes bit 0 of the word, and the sixteenth becomes bit 15.
- R3: A committed word with bit 15 = 0 is written to the configuration register (`sys_word`). The attenuation outputs do not change.
- R4: A committed word with bit 15 = 1 is written to the attenuation register (`att_word`). Its fields decode as `mute` = bit 14, `deemph_en` = bit 13, `deemph_sel` = bits 12:11 and `att_level` = bits 7:0. `sys_word` does not change.
- R5: Shifting alone never changes an output. A word is committed only on a falling edge of the latch strobe, and the outputs show it on the third rising edge of `clk` after the strobe falls.
- R6: A latch falling edge that follows fewer than 16 shift clocks discards the word and clears the bit count, so the next full word loads correctly.
- R7: If more than 16 bits are shifted before the latch edge, the last 16 bits form the word.
- R8: `zd_sel` always equals bits 5:4 of the configuration register.
- R9: While `init_n` is low, both registers clear to zero on the next clock edge, and any partly shifted word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_n | input | 1 | Synchronous active-low clear of both registers |
| ser_clk | input | 1 | Serial shift clock; a bit is taken on its rising edge; idles high |
| ser_dat | input | 1 | Serial data, least significant bit first |
| ser_lat | input | 1 | Latch strobe; commits on its falling edge; idles high |
| sys_word | output | 16 | Configuration register contents |
| zd_sel | output | 2 | Zero-detect period select, configuration bits 5:4 |
| att_word | output | 16 | Attenuation register contents |
| att_level | output | 8 | Output level field |
| deemph_en | output | 1 | De-emphasis enable |
| deemph_sel | output | 2 | De-emphasis rate select |
| mute | output | 1 | Mute bit |

## Verification
A committed word reaches the outputs on the third rising clock edge after the strobe falls: two synchroniser stages, then the register write. The bench changes every input on a falling clock edge and samples on a falling edge. In the timing test it reads the outputs after the second rising edge and expects the old value, then after the third and expects the new one. A clear from `init_n` is due after a single rising edge. Every serial phase is held for three clocks, so each level passes the synchroniser before the next edge arrives.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
   // bit positions inside the synchronised serial bundle
   localparam int unsigned SIG_DAT = 0;
   localparam int unsigned SIG_CLK = 1;
   localparam int unsigned SIG_LAT = 2;
   localparam int unsigned SIG_N   = 3;

   // idle levels: shift clock and strobe rest high
   localparam logic [SIG_N-1:0] SIG_IDLE = 3'b110;

   typedef enum logic {
      DEST_SYS = 1'b0,
      DEST_ATT = 1'b1
   } dest_e;

   function automatic int unsigned bits_for(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
   parameter int unsigned W       = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ctl_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("ctl_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ctl_shift_rx.sv
module ctl_shift_rx
   import ctl_pkg::*;
#(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_n,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              slat_s,
   output logic              commit,
   output logic [WORD_W-1:0] word
);
   localparam int unsigned     CNT_W = bits_for(WORD_W);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

   if (WORD_W < 8) begin : g_bad_word
      $error("ctl_shift_rx: WORD_W must be at least 8");
   end

   logic              sclk_d, slat_d;
   logic              clk_rise, lat_fall;
   logic [WORD_W-1:0] shreg_q;
   logic [CNT_W-1:0]  cnt_q;

   assign clk_rise = sclk_s & ~sclk_d;
   assign lat_fall = ~slat_s & slat_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b1;
         slat_d  <= 1'b1;
         shreg_q <= '0;
         cnt_q   <= '0;
      end else begin
         sclk_d <= sclk_s;
         slat_d <= slat_s;
         if (clk_rise) shreg_q <= {sdat_s, shreg_q[WORD_W-1:1]};
         if (!init_n || lat_fall)          cnt_q <= '0;
         else if (clk_rise && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign commit = lat_fall & (cnt_q == FULL) & init_n;
   assign word   = shreg_q;

   // R7: count saturates at a full word
   a_r7_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);
   // R6: any strobe edge restarts the count
   a_r6_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      lat_fall |=> cnt_q == '0);
   // R9: initialise discards a partial word
   a_r9_init_clears_cnt: assert property (@(posedge clk) disable iff (!rst_n)
      !init_n |=> cnt_q == '0);
endmodule

// File: rtl/ctl_word_loader.sv
module ctl_word_loader
   import ctl_pkg::*;
#(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned LVL_W       = 8,
   parameter int unsigned ZD_LSB      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_lat,
   output logic [WORD_W-1:0] sys_word,
   output logic [1:0]        zd_sel,
   output logic [WORD_W-1:0] att_word,
   output logic [LVL_W-1:0]  att_level,
   output logic              deemph_en,
   output logic [1:0]        deemph_sel,
   output logic              mute
);
   localparam int unsigned DEST_BIT = WORD_W - 1;
   localparam int unsigned MUTE_BIT = WORD_W - 2;
   localparam int unsigned DEN_BIT  = WORD_W - 3;
   localparam int unsigned DSEL_HI  = WORD_W - 4;
   localparam int unsigned DSEL_LO  = WORD_W - 5;

   if (LVL_W > DSEL_LO) begin : g_bad_lvl
      $error("ctl_word_loader: LVL_W overlaps the de-emphasis field");
   end
   if (ZD_LSB + 2 > DEST_BIT) begin : g_bad_zd
      $error("ctl_word_loader: ZD_LSB overlaps the destination bit");
   end

   logic [SIG_N-1:0]  sig_s;
   logic              commit;
   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] sys_q, att_q;
   dest_e             dest;

   ctl_sync #(
      .W       (SIG_N),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SIG_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_lat, ser_clk, ser_dat}),
      .q     (sig_s)
   );

   ctl_shift_rx #(
      .WORD_W (WORD_W)
   ) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .init_n (init_n),
      .sclk_s (sig_s[SIG_CLK]),
      .sdat_s (sig_s[SIG_DAT]),
      .slat_s (sig_s[SIG_LAT]),
      .commit (commit),
      .word   (word)
   );

   assign dest = dest_e'(word[DEST_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_q <= '0;
         att_q <= '0;
      end else if (!init_n) begin
         sys_q <= '0;
         att_q <= '0;
      end else if (commit) begin
         if (dest == DEST_ATT) att_q <= word;
         else                  sys_q <= word;
      end
   end

   assign sys_word   = sys_q;
   assign zd_sel     = sys_q[ZD_LSB+1:ZD_LSB];
   assign att_word   = att_q;
   assign att_level  = att_q[LVL_W-1:0];
   assign deemph_en  = att_q[DEN_BIT];
   assign deemph_sel = att_q[DSEL_HI:DSEL_LO];
   assign mute       = att_q[MUTE_BIT];

   // R5: registers move only on a commit or a clear
   a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (init_n && !commit) |=> ($stable(sys_q) && $stable(att_q)));
   // R3: configuration destination
   a_r3_sys_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (init_n && commit && !word[DEST_BIT]) |=> (sys_q == $past(word) && $stable(att_q)));
   // R4: attenuation destination
   a_r4_att_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (init_n && commit && word[DEST_BIT]) |=> (att_q == $past(word) && $stable(sys_q)));
   // R9: initialise clears both registers
   a_r9_init_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !init_n |=> (sys_q == '0 && att_q == '0));
endmodule

// File: tb/sim_ctl_word_loader.sv
module sim_ctl_word_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_n = 1'b1;
   logic        ser_clk = 1'b1;
   logic        ser_dat = 1'b0;
   logic        ser_lat = 1'b1;
   logic [15:0] sys_word, att_word;
   logic [1:0]  zd_sel, deemph_sel;
   logic [7:0]  att_level;
   logic        deemph_en, mute;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   ctl_word_loader u0 (
      .clk(clk), .rst_n(rst_n), .init_n(init_n),
      .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
      .sys_word(sys_word), .zd_sel(zd_sel), .att_word(att_word),
      .att_level(att_level), .deemph_en(deemph_en),
      .deemph_sel(deemph_sel), .mute(mute)
   );

   // word, expected configuration register, expected {mute,den,dsel,level}
   localparam logic [43:0] VEC [6] = '{
      {16'h0030, 16'h0030, 12'h000},
      {16'hC0A5, 16'h0030, 12'h8A5},
      {16'h3A5F, 16'h3A5F, 12'h8A5},
      {16'hB87E, 16'h3A5F, 12'h77E},
      {16'h0010, 16'h0010, 12'h77E},
      {16'h8000, 16'h0010, 12'h000}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = 0; i < n; i++) begin
         ser_clk = 1'b0;
         ser_dat = v[i];
         wait_n(3);
         ser_clk = 1'b1;
         wait_n(3);
      end
   endtask

   task automatic strobe();
      wait_n(2);
      ser_lat = 1'b0;
      wait_n(4);
      ser_lat = 1'b1;
      wait_n(4);
   endtask

   function automatic logic [11:0] att_fields();
      return {mute, deemph_en, deemph_sel, att_level};
   endfunction

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(3);
      // R1: reset state
      chk("R1 sys_word", 32'(sys_word), 32'h0);
      chk("R1 att fields", 32'(att_fields()), 32'h0);
      chk("R1 att_word", 32'(att_word), 32'h0);

      foreach (VEC[k]) begin
         send_bits(32'(VEC[k][43:28]), 16);
         strobe();
         chk("R2/R3 sys_word", 32'(sys_word), 32'(VEC[k][27:12]));
         chk("R3/R4 att fields", 32'(att_fields()), 32'(VEC[k][11:0]));
         chk("R8 zd_sel", 32'(zd_sel), 32'(VEC[k][17:16]));
      end

      // R5: shifting alone has no effect; commit lands on the third edge
      send_bits(32'h1234, 16);
      wait_n(2);
      chk("R5 no change while shifting", 32'(sys_word), 32'h0010);
      ser_lat = 1'b0;
      wait_n(2);
      chk("R5 old value two edges after strobe", 32'(sys_word), 32'h0010);
      wait_n(1);
      chk("R5 new value three edges after strobe", 32'(sys_word), 32'h1234);
      wait_n(3);
      ser_lat = 1'b1;
      wait_n(4);

      // R6: short word discarded, next full word fine
      send_bits(32'hFFFF, 9);
      strobe();
      chk("R6 short word ignored sys", 32'(sys_word), 32'h1234);
      chk("R6 short word ignored att", 32'(att_word), 32'h8000);
      send_bits(32'h0021, 16);
      strobe();
      chk("R6 full word after short", 32'(sys_word), 32'h0021);

      // R7: last 16 of 20 bits kept
      send_bits(32'h04321, 20);
      strobe();
      chk("R7 overlong word", 32'(sys_word), 32'h0432);

      // R9: initialise clears registers and partial word
      send_bits(32'hC0FF, 16);
      strobe();
      chk("R4 att before init", 32'(att_word), 32'hC0FF);
      send_bits(32'h00AB, 8);
      init_n = 1'b0;
      wait_n(1);
      init_n = 1'b1;
      chk("R9 sys cleared", 32'(sys_word), 32'h0);
      chk("R9 att cleared", 32'(att_word), 32'h0);
      send_bits(32'h00AB, 8);
      strobe();
      chk("R9 partial word discarded", 32'(sys_word), 32'h0);
      send_bits(32'h0055, 16);
      strobe();
      chk("R9 load after init", 32'(sys_word), 32'h0055);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule